// File: doc/BRIEF.md
# Post-Reset Control State and Interrupt Gate

This block keeps the reset-time control state of a small 4-bit processor core. It holds the program counter start value, the interrupt enable flag, and the one-shot extension flag. It also tracks whether software has written each of the two stack pointers. Reset loads the defined values. After reset, every interrupt source stays blocked until both stack pointers have been written, and that includes the non-maskable one. Only then can the interrupt flag let maskable requests through.

The surrounding core sends a strobe for each register write and a strobe each time an instruction retires. A write to the 8-bit extension register starts an extended-addressing window. That window covers the next instruction only. The flag drops when that instruction retires. Instruction decode and the datapath are not part of this block.

Two small state machines do the work.

The stack-pointer tracker has four states: `SPW_NONE`, `SPW_ONLY1`, `SPW_ONLY2` and `SPW_BOTH`. Its transitions are:
- NONE goes to ONLY1 on a write to the first pointer.
- NONE goes to ONLY2 on a write to the second pointer.
- NONE goes straight to BOTH when both are written in the same cycle.
- ONLY1 goes to BOTH on a write to the second pointer.
- ONLY2 goes to BOTH on a write to the first pointer.
- BOTH is left only by reset.

The extension window has two states, `EXT_IDLE` and `EXT_ARMED`. Its transitions are:
- IDLE goes to ARMED on an extension write.
- ARMED goes back to IDLE on a retire strobe with no extension write in the same cycle.
- ARMED stays ARMED on a fresh extension write.

Top module: `boot_state_gate`

## Requirements
- R1: While reset is asserted and right after it ends, the outputs are: `boot_pc` = 0x0110, `int_flag` = 0, `ext_flag` = 0, `sp1_seen` = 0, `sp2_seen` = 0, `irq_permit` = 0 and `nmi_permit` = 0.
- R2: A write to only one stack pointer, repeated any number of times, leaves both `nmi_permit` and `irq_permit` at 0.
- R3: `nmi_permit` rises on the clock edge that samples the write completing the pair. This holds for either write order and for two writes in the same cycle.
- R4: Once both pointers have been written, `nmi_permit`, `sp1_seen` and `sp2_seen` stay at 1 until reset, whatever further writes arrive.
- R5: `irq_permit` is 1 exactly when `int_flag` is 1 and both pointers have been written. A set interrupt flag alone does not permit interrupts.
- R6: A cycle with `wr_iflag` = 1 loads `iflag_din` into `int_flag` at that edge.
- R7: A cycle with `wr_ext` = 1 sets `ext_flag` at that edge. The retire strobe of that same cycle (the retire of the write instruction itself) does not count.
- R8: With `ext_flag` = 1, the first later cycle that has `retire` = 1 and `wr_ext` = 0 clears `ext_flag` at that edge. Cycles without a retire leave it set.
- R9: An extension write in a cycle where `ext_flag` is already 1 keeps it at 1, even when `retire` is also 1.
- R10: `boot_pc` holds 0x0110 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_sp1 | input | 1 | Write strobe, stack pointer 1 |
| wr_sp2 | input | 1 | Write strobe, stack pointer 2 |
| wr_ext | input | 1 | Write strobe, extension register |
| wr_iflag | input | 1 | Write strobe, interrupt flag |
| iflag_din | input | 1 | Value written to the interrupt flag |
| retire | input | 1 | One instruction retired this cycle |
| boot_pc | output | 16 | Program counter start value |
| int_flag | output | 1 | Interrupt enable flag |
| ext_flag | output | 1 | Extended-addressing flag for the next instruction |
| sp1_seen | output | 1 | Stack pointer 1 has been written since reset |
| sp2_seen | output | 1 | Stack pointer 2 has been written since reset |
| irq_permit | output | 1 | Maskable interrupts may be taken |
| nmi_permit | output | 1 | Non-maskable interrupt may be taken |

## Verification
Every result is due one clock edge after the strobe that causes it:
- Pointer-written indicators and `nmi_permit` follow the sampled write edge.
- `ext_flag` follows the edge that samples the extension write or the clearing retire.
- `int_flag` and `irq_permit` follow the edge that samples the flag write.

The bench drives each stimulus on a falling edge and reads the outputs at the next falling edge, so exactly one rising edge lies between them. Before that edge, in the same cycle as the completing pointer write, it also confirms that `nmi_permit` is still low. This shows the output is not combinational from the strobe.

// File: rtl/boot_state_pkg.sv
package boot_state_pkg;

    typedef enum logic [1:0] {
        SPW_NONE  = 2'd0,
        SPW_ONLY1 = 2'd1,
        SPW_ONLY2 = 2'd2,
        SPW_BOTH  = 2'd3
    } spw_state_t;

    typedef enum logic {
        EXT_IDLE  = 1'b0,
        EXT_ARMED = 1'b1
    } ext_state_t;

endpackage

// File: rtl/sp_pair_tracker.sv
module sp_pair_tracker
    import boot_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_a,
    input  logic wr_b,
    output logic a_done,
    output logic b_done,
    output logic pair_done
);

    spw_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SPW_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPW_NONE: begin
                if (wr_a && wr_b) state_d = SPW_BOTH;
                else if (wr_a)    state_d = SPW_ONLY1;
                else if (wr_b)    state_d = SPW_ONLY2;
            end
            SPW_ONLY1: if (wr_b) state_d = SPW_BOTH;
            SPW_ONLY2: if (wr_a) state_d = SPW_BOTH;
            SPW_BOTH:  state_d = SPW_BOTH;
        endcase
    end

    always_comb begin
        a_done    = 1'b0;
        b_done    = 1'b0;
        pair_done = 1'b0;
        unique case (state_q)
            SPW_NONE:  ;
            SPW_ONLY1: a_done = 1'b1;
            SPW_ONLY2: b_done = 1'b1;
            SPW_BOTH: begin
                a_done    = 1'b1;
                b_done    = 1'b1;
                pair_done = 1'b1;
            end
        endcase
    end

    // R4
    pair_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> pair_done);

    // R3
    pair_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_done) |-> $past(wr_a || wr_b));

    // R2
    pair_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |-> (a_done && b_done));

endmodule

// File: rtl/ext_window.sv
module ext_window
    import boot_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_wr,
    input  logic retire,
    output logic ext_active
);

    ext_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_IDLE:  if (ext_wr) state_d = EXT_ARMED;
            EXT_ARMED: if (!ext_wr && retire) state_d = EXT_IDLE;
        endcase
    end

    always_comb begin
        ext_active = 1'b0;
        unique case (state_q)
            EXT_IDLE:  ext_active = 1'b0;
            EXT_ARMED: ext_active = 1'b1;
        endcase
    end

    // R7
    ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |=> ext_active);

    // R8
    ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_active && retire && !ext_wr) |=> !ext_active);

    // R8
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_active && !retire) |=> ext_active);

endmodule

// File: rtl/boot_state_gate.sv
module boot_state_gate #(
    parameter int          PC_W     = 16,
    parameter logic [15:0] RESET_PC = 16'h0110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sp1,
    input  logic            wr_sp2,
    input  logic            wr_ext,
    input  logic            wr_iflag,
    input  logic            iflag_din,
    input  logic            retire,
    output logic [PC_W-1:0] boot_pc,
    output logic            int_flag,
    output logic            ext_flag,
    output logic            sp1_seen,
    output logic            sp2_seen,
    output logic            irq_permit,
    output logic            nmi_permit
);

    localparam logic [PC_W-1:0] PC_VEC = PC_W'(RESET_PC);

    logic [PC_W-1:0] pc_q;
    logic            iflag_q;
    logic            pair_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= PC_VEC;
        else        pc_q <= pc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        iflag_q <= 1'b0;
        else if (wr_iflag) iflag_q <= iflag_din;
    end

    sp_pair_tracker u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_a      (wr_sp1),
        .wr_b      (wr_sp2),
        .a_done    (sp1_seen),
        .b_done    (sp2_seen),
        .pair_done (pair_ok)
    );

    ext_window u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_wr     (wr_ext),
        .retire     (retire),
        .ext_active (ext_flag)
    );

    assign boot_pc    = pc_q;
    assign int_flag   = iflag_q;
    assign nmi_permit = pair_ok;
    assign irq_permit = iflag_q & pair_ok;

    // R10
    pc_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_pc == PC_VEC);

    // R6
    iflag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_iflag |=> (int_flag == $past(iflag_din)));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_permit |-> !irq_permit);

endmodule

// File: tb/boot_state_gate_test.sv
module boot_state_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_sp1 = 1'b0, wr_sp2 = 1'b0, wr_ext = 1'b0;
    logic        wr_iflag = 1'b0, iflag_din = 1'b0, retire = 1'b0;
    logic [15:0] boot_pc;
    logic        int_flag, ext_flag, sp1_seen, sp2_seen, irq_permit, nmi_permit;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    boot_state_gate uut (
        .clk(clk), .rst_n(rst_n), .wr_sp1(wr_sp1), .wr_sp2(wr_sp2),
        .wr_ext(wr_ext), .wr_iflag(wr_iflag), .iflag_din(iflag_din),
        .retire(retire), .boot_pc(boot_pc), .int_flag(int_flag),
        .ext_flag(ext_flag), .sp1_seen(sp1_seen), .sp2_seen(sp2_seen),
        .irq_permit(irq_permit), .nmi_permit(nmi_permit)
    );

    // {sp1,sp2,ext,ret,wif,din, exp_irq,exp_nmi,exp_e,exp_i}
    localparam int NV = 15;
    localparam logic [9:0] VEC [NV] = '{
        10'b000011_0001, // R5: flag set alone does not permit
        10'b100000_0001, // R2: single write
        10'b100000_0001, // R2: repeated same pointer
        10'b000000_0001, // R2: idle
        10'b010000_1101, // R3: pair completes
        10'b001100_1111, // R7: ext write with its own retire
        10'b000000_1111, // R8: no retire keeps it
        10'b000100_1101, // R8: next retire clears
        10'b000100_1101, // R8: stays clear
        10'b000010_0100, // R6 R5: flag cleared drops irq
        10'b100000_0100, // R4: later write keeps permit
        10'b001000_0110, // R7: ext write without retire
        10'b001100_0110, // R9: re-arm wins over retire
        10'b000100_0100, // R8: clears
        10'b000011_1101  // R5 R6: irq back
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_sp1 = 0; wr_sp2 = 0; wr_ext = 0; wr_iflag = 0; iflag_din = 0; retire = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<5000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: during reset
        @(negedge clk);
        chk("R1 pc in reset", 32'(boot_pc), 32'h0110);
        chk("R1 flags in reset", {int_flag, ext_flag, sp1_seen, sp2_seen, irq_permit, nmi_permit}, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 flags after reset", {int_flag, ext_flag, sp1_seen, sp2_seen, irq_permit, nmi_permit}, 0);
        chk("R10 pc after reset", 32'(boot_pc), 32'h0110);

        for (int k = 0; k < NV; k++) begin
            {wr_sp1, wr_sp2, wr_ext, retire, wr_iflag, iflag_din} = VEC[k][9:4];
            @(negedge clk);
            chk($sformatf("vec%0d R2 R3 R4 R5 R6 R7 R8 R9", k),
                {irq_permit, nmi_permit, ext_flag, int_flag}, 32'(VEC[k][3:0]));
            idle_inputs();
        end
        chk("R4 seen flags held", {sp1_seen, sp2_seen}, 2'b11);
        chk("R10 pc held", 32'(boot_pc), 32'h0110);

        // R3: reverse order, with the one-edge timing
        do_reset();
        wr_sp2 = 1;
        @(negedge clk);
        wr_sp2 = 0;
        chk("R2 only sp2 nmi", nmi_permit, 0);
        chk("R2 only sp2 seen", {sp1_seen, sp2_seen}, 2'b01);
        wr_sp1 = 1;
        #1;
        chk("R3 not before edge", nmi_permit, 0);
        @(negedge clk);
        wr_sp1 = 0;
        chk("R3 reverse order", nmi_permit, 1);
        chk("R5 flag clear blocks irq", irq_permit, 0);

        // R3: simultaneous writes
        do_reset();
        wr_sp1 = 1; wr_sp2 = 1;
        @(negedge clk);
        idle_inputs();
        chk("R3 same cycle", {sp1_seen, sp2_seen, nmi_permit}, 3'b111);

        // R1: reset mid-run clears everything
        wr_ext = 1; wr_iflag = 1; iflag_din = 1;
        @(negedge clk);
        idle_inputs();
        chk("R7 R6 armed before reset", {ext_flag, int_flag, irq_permit}, 3'b111);
        do_reset();
        chk("R1 reset mid-run", {int_flag, ext_flag, sp1_seen, sp2_seen, irq_permit, nmi_permit}, 0);
        chk("R1 pc mid-run", 32'(boot_pc), 32'h0110);

        // R8: retires spaced out; only the first clears
        wr_ext = 1;
        @(negedge clk);
        wr_ext = 0;
        repeat (3) @(negedge clk);
        chk("R8 held over idle cycles", ext_flag, 1);
        retire = 1;
        @(negedge clk);
        retire = 0;
        chk("R8 cleared by retire", ext_flag, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule